// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Result Port

This block is the digital side of a delta-sigma converter's three-wire read-out port. It cycles through three phases: converting, sleeping with a finished result, and shifting that result out. A counter of fixed length stands in for the modulator and decimation filter. When the counter expires, the block captures the sign, the 24-bit code and five sub-LSB bits from a parallel result port. It packs them into a 32-bit word and holds that word in a static shift register until a host reads it.

The host drives an active-low chip select and a serial clock. Both pins are asynchronous to the system clock, so each passes through a two-flop synchronizer, and edges are found on the synchronized copies. The clock-source mode is latched at every falling edge of chip select. If the serial clock is low at that edge, the host supplies the clock and the word advances one bit on each falling edge of that clock. If the serial clock is high, the internal-clock mode is flagged, but that clock is not generated and the word does not advance. Raising chip select in the middle of a read discards the rest of the word and starts a new conversion at once. Because the result is always the conversion that has just finished, there is no pipeline latency.

Top module: `dsadc_serial_port`

## Requirements
- R1: After reset the block is converting, `sdo_oe` is low, and `sdo` reads high as soon as chip select is low.
- R2: A conversion lasts CONV_CYCLES system clocks. During it `sdo` is 1 (not ready). When it ends the result inputs are captured and `sdo` drops to 0.
- R3: The result word is sent MSB first as {ready_n(bit 31)=0, 1'b0 (bit 30), sign (bit 29), code[23:0] (bits 28..5), sub[4:0] (bits 4..0)}.
- R4: `sdo` moves to the next bit only on a falling edge of the serial clock and is unchanged after a rising edge.
- R5: At each chip-select falling edge, a high serial clock sets `int_clk_mode` to 1 and a low one clears it. In internal-clock mode, serial-clock falling edges do not advance the word.
- R6: After the 32nd falling edge of the serial clock, `sdo` goes high and a new conversion of CONV_CYCLES clocks begins.
- R7: Raising chip select before all 32 bits are clocked ends the read. A new conversion starts, so `sdo` is high at the next chip-select low until that conversion ends.
- R8: While chip select stays high after a conversion ends, the result is held unchanged for any length of time, and later changes on the result inputs do not alter it.
- R9: `sdo_oe` is high only while the synchronized chip select is low.
- R10: The word read out holds the input values present when the conversion just finished, not those of an earlier conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from host (asynchronous) |
| sck | input | 1 | Serial clock from host (asynchronous) |
| res_sign | input | 1 | Sign of the result (1 = positive) |
| res_code | input | 24 | Result code, MSB first on the wire |
| res_sub | input | 5 | Sub-LSB bits of the result |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (low models high impedance) |
| int_clk_mode | output | 1 | Internal serial-clock mode latched at the last chip-select fall |

## Verification
On every cycle the assertions check the following:
- `sdo` does not move between serial-clock falling edges.
- The internal-clock mode never shifts.
- The 32nd falling edge and any early chip-select rise both return the block to converting with `sdo` high.
- A sleeping result stays frozen.
- The end of a conversion always presents a ready flag of 0.

Only the bench scenarios can show the following:
- The exact bit order and field positions of the word.
- That the word read is the one captured at the end of the latest conversion, and not an older or newer input value.
- The conversion length.
- The mode chosen by the serial-clock level at the chip-select edge.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  localparam int WORD_W = 32;
  localparam int CODE_W = 24;
  localparam int SUB_W  = 5;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DOUT  = 2'd2
  } port_state_t;

  // Result word: ready flag (0 = ready), fixed zero, sign, code, sub-LSB bits.
  function automatic logic [WORD_W-1:0] pack_word(input logic sign,
                                                  input logic [CODE_W-1:0] code,
                                                  input logic [SUB_W-1:0] sub);
    return {1'b0, 1'b0, sign, code, sub};
  endfunction
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dsadc_conv_timer.sv
module dsadc_conv_timer #(
  parameter int CONV_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run||done) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dsadc_out_shifter.sv
module dsadc_out_shifter #(
  parameter int WORD_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [WORD_W-1:0]          load_word,
  input  logic                       shift,
  output logic [WORD_W-1:0]          word_q,
  output logic [$clog2(WORD_W)-1:0]  bit_cnt,
  output logic                       last
);
  localparam int CNT_W = $clog2(WORD_W);

  assign last = (bit_cnt == CNT_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '1;
      bit_cnt <= '0;
    end else if (load) begin
      word_q  <= load_word;
      bit_cnt <= '0;
    end else if (shift) begin
      word_q  <= {word_q[WORD_W-2:0], 1'b1};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dsadc_serial_port.sv
module dsadc_serial_port
  import dsadc_pkg::*;
#(
  parameter int CONV_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              res_sign,
  input  logic [CODE_W-1:0] res_code,
  input  logic [SUB_W-1:0]  res_sub,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              int_clk_mode
);
  localparam int CNT_W = $clog2(WORD_W);

  // Named internal events, brought out for the checker.
  logic              cs_s, sck_s, cs_p, sck_p;
  logic              cs_fall, sck_fall;
  logic              conv_done, shift_en, last_bit;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  bit_cnt;
  port_state_t       st_q, st_d;

  dsadc_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck}), .q({cs_s, sck_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p  <= 1'b1;
      sck_p <= 1'b1;
    end else begin
      cs_p  <= cs_s;
      sck_p <= sck_s;
    end
  end

  assign cs_fall  = cs_p && !cs_s;
  assign sck_fall = sck_p && !sck_s;

  dsadc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_CONV), .done(conv_done)
  );

  assign shift_en = (st_q == ST_DOUT) && sck_fall && !cs_s && !int_clk_mode;

  dsadc_out_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(conv_done),
    .load_word(pack_word(res_sign, res_code, res_sub)),
    .shift(shift_en), .word_q(word_q), .bit_cnt(bit_cnt), .last(last_bit)
  );

  // Clock-source mode, latched on every chip-select fall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       int_clk_mode <= 1'b0;
    else if (cs_fall) int_clk_mode <= sck_s;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CONV:  if (conv_done) st_d = ST_SLEEP;
      ST_SLEEP: if (!cs_s)     st_d = ST_DOUT;
      ST_DOUT: begin
        if (cs_s)                      st_d = ST_CONV;
        else if (shift_en && last_bit) st_d = ST_CONV;
      end
      default: st_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_CONV;
    else        st_q <= st_d;
  end

  assign sdo    = (st_q == ST_CONV) ? 1'b1 : word_q[WORD_W-1];
  assign sdo_oe = !cs_s;
endmodule

// File: rtl/dsadc_port_chk.sv
module dsadc_port_chk
  import dsadc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input port_state_t       st,
  input logic              cs_s,
  input logic              sck_fall,
  input logic              shift,
  input logic              last,
  input logic              conv_done,
  input logic              sdo,
  input logic              int_mode,
  input logic [WORD_W-1:0] word_q,
  input logic [CNT_W-1:0]  bit_cnt
);
  // R1
  conv_sdo_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CONV) |-> sdo);

  // R2
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (st != ST_CONV && !sdo && bit_cnt == '0));

  // R4
  hold_between_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DOUT && !cs_s && !sck_fall) |=> $stable(sdo));

  // R5
  int_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DOUT && int_mode) |-> !shift);

  // R6
  last_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && last) |=> (st == ST_CONV && sdo));

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DOUT && cs_s) |=> (st == ST_CONV));

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP && cs_s) |=> (st == ST_SLEEP && $stable(word_q)));
endmodule

bind dsadc_serial_port dsadc_port_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .cs_s(cs_s), .sck_fall(sck_fall),
  .shift(shift_en), .last(last_bit), .conv_done(conv_done), .sdo(sdo),
  .int_mode(int_clk_mode), .word_q(word_q), .bit_cnt(bit_cnt)
);

// File: tb/sim_dsadc_serial_port.sv
module sim_dsadc_serial_port;
  localparam int CONV = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        res_sign = 1'b0;
  logic [23:0] res_code = '0;
  logic [4:0]  res_sub = '0;
  logic        sdo, sdo_oe, int_clk_mode;

  int errors = 0;
  int checks = 0;

  logic [31:0] exp_q[$];
  logic [31:0] rx_word;
  event        rx_ev;

  always #10 clk = ~clk;

  dsadc_serial_port #(.CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .res_sign(res_sign), .res_code(res_code), .res_sub(res_sub),
    .sdo(sdo), .sdo_oe(sdo_oe), .int_clk_mode(int_clk_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Independent model of the word layout (R3).
  function automatic logic [31:0] model_word(input logic s, input logic [23:0] c,
                                             input logic [4:0] u);
    logic [31:0] w;
    w = '0;
    w[29] = s;
    for (int i = 0; i < 24; i++) w[5 + i] = c[i];
    for (int i = 0; i < 5; i++)  w[i] = u[i];
    return w;
  endfunction

  task automatic expect_word(input logic s, input logic [23:0] c, input logic [4:0] u);
    exp_q.push_back(model_word(s, c, u));
  endtask

  // Clock n serial-clock pulses, sampling sdo before each; chip select already low.
  task automatic read_bits(input int n, output logic [31:0] w);
    w = '1;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = sdo;
      w[31 - i] = b;
      sck = 1'b1;
      clks(5);
      chk("R4 sdo unchanged after rising edge", {31'd0, sdo}, {31'd0, b});
      sck = 1'b0;
      clks(5);
    end
  endtask

  task automatic read_full();
    logic [31:0] w;
    read_bits(32, w);
    rx_word = w;
    ->rx_ev;
    clks(1);
    chk("R6 sdo high after 32nd falling edge", {31'd0, sdo}, 32'd1);
  endtask

  // Monitor: pops expected words as the design delivers them (R3, R10).
  initial begin
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) begin
        chk("R3 unexpected word", rx_word, 32'hxxxxxxxx);
      end else begin
        chk("R3/R10 word content", rx_word, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] part;
    res_sign = 1'b1; res_code = 24'hA5C3F1; res_sub = 5'b10110;
    clks(3);
    chk("R1 oe low in reset", {31'd0, sdo_oe}, 32'd0);
    rst_n = 1'b1;
    cs_n = 1'b0;
    clks(6);
    chk("R9 oe high with cs low", {31'd0, sdo_oe}, 32'd1);
    chk("R1 sdo high while converting", {31'd0, sdo}, 32'd1);
    clks(44);
    chk("R2 still converting mid-way", {31'd0, sdo}, 32'd1);
    clks(60);
    chk("R2 ready after conversion", {31'd0, sdo}, 32'd0);
    chk("R5 external mode with sck low", {31'd0, int_clk_mode}, 32'd0);
    expect_word(1'b1, 24'hA5C3F1, 5'b10110);
    read_full();

    // R10 / R8: inputs set during conversion are read; later changes ignored.
    cs_n = 1'b1;
    clks(20);
    res_sign = 1'b0; res_code = 24'h0F00FF; res_sub = 5'b00011;
    clks(150);
    chk("R9 oe low with cs high", {31'd0, sdo_oe}, 32'd0);
    res_sign = 1'b1; res_code = 24'h123456; res_sub = 5'b11001;
    clks(200);
    cs_n = 1'b0;
    clks(6);
    chk("R8 result held while sleeping", {31'd0, sdo}, 32'd0);
    expect_word(1'b0, 24'h0F00FF, 5'b00011);
    read_full();

    // R7: abort after 8 bits.
    cs_n = 1'b1;
    clks(150);
    cs_n = 1'b0;
    clks(6);
    read_bits(8, part);
    chk("R7 partial bits match word", {24'd0, part[31:24]},
        {24'd0, model_word(1'b1, 24'h123456, 5'b11001) >> 24});
    cs_n = 1'b1;
    clks(10);
    cs_n = 1'b0;
    clks(6);
    chk("R7 new conversion after abort", {31'd0, sdo}, 32'd1);
    clks(120);
    chk("R7 ready after restarted conversion", {31'd0, sdo}, 32'd0);
    expect_word(1'b1, 24'h123456, 5'b11001);
    read_full();

    // R5: internal mode selected with sck high; falling edges do not shift.
    cs_n = 1'b1;
    res_sign = 1'b1; res_code = 24'hFFFFFF; res_sub = 5'b11111;
    clks(150);
    sck = 1'b1;
    clks(6);
    cs_n = 1'b0;
    clks(6);
    chk("R5 internal mode flagged", {31'd0, int_clk_mode}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; clks(5);
      sck = 1'b1; clks(5);
    end
    chk("R5 no shift in internal mode", {31'd0, sdo}, 32'd0);
    sck = 1'b0;
    clks(6);
    cs_n = 1'b1;
    clks(6);
    cs_n = 1'b0;
    clks(6);
    chk("R5 external mode after low-sck fall", {31'd0, int_clk_mode}, 32'd0);
    chk("R7 abort restarted conversion", {31'd0, sdo}, 32'd1);
    cs_n = 1'b1;
    clks(4);
    chk("R3 no unread words left", exp_q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule